// File: doc/BRIEF.md
# Snoop Response and Push Controller

This block is the snooping half of a cache-coherent bus agent. For each address tenure of another master, it takes the result of the cache's snoop lookup: miss, shared, exclusive or modified. It then drives a HIT indication to announce that it will supply the data by intervention. The length of the HIT pulse tells the memory controller whether it must capture (snarf) the intervened data. A two-cycle pulse means the data is clean and needs no capture. A single-cycle pulse means the data is dirty and memory must take a copy. A read-with-intent-to-modify always gets the two-cycle form.

The block samples the shared address-retry line during the response window. If another device retries a transaction in which this agent reported a modified hit, the agent uses that opening to cast the dirty line out. It raises its bus request in the next cycle and holds it until the grant is seen. It then starts a one-cycle write-with-kill address tenure carrying the line-aligned address, and at the same time pulses push-done so the cache can clean the line. While a castout is pending, the block raises `busy` and accepts no new snoops, which leaves them to be retried externally.

Top module: `snoop_push_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `hit_o`, `bus_req`, `tstart`, `push_done` and `busy` are all low.
- R2: A snoop strobe with state 2'b00 (miss) produces no HIT and no bus request.
- R3: For state 2'b01 (shared) or 2'b10 (exclusive), `hit_o` is high in the window cycle, which is RETRY_WIN cycles after the strobe cycle (2 by default). It is also high in the one cycle that follows and in no other cycle.
- R4: For state 2'b11 (modified) on a transaction type other than RWITM_CODE (4'h6), with no retry, `hit_o` is high in the window cycle only and no bus request follows.
- R5: For state 2'b11 on a transaction of type RWITM_CODE with no retry, `hit_o` uses the two-cycle form of R3.
- R6: When a shared or exclusive hit sees `artry_in` high in the window cycle, HIT still takes the two-cycle form and no push is started.
- R7: When a modified hit sees `artry_in` high in the window cycle, `hit_o` is low in the next cycle. `bus_req` rises in that next cycle and stays high until `bus_grant` is sampled high. This also applies to a transaction of type RWITM_CODE.
- R8: In the cycle after `bus_grant` is sampled with `bus_req` high, `tstart` and `push_done` are high for exactly one cycle. In that cycle `push_type` is 4'h3 (write-with-kill), `push_addr` is the snooped address with its low LINE_OFF bits (5) cleared, and `bus_req` is low.
- R9: `busy` is high from the first `bus_req` cycle through the `tstart` cycle. A snoop strobe that arrives while `busy` is high produces no HIT at any later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| snp_valid | input | 1 | Snoop strobe, one cycle, marks the start of an external transaction |
| snp_state | input | 2 | Lookup result: 00 miss, 01 shared, 10 exclusive, 11 modified |
| snp_type | input | TYPE_W | Transaction type of the snooped tenure |
| snp_addr | input | ADDR_W | Address of the snooped tenure |
| artry_in | input | 1 | Shared address-retry line, active high |
| bus_grant | input | 1 | Address bus grant |
| hit_o | output | 1 | Intervention indication |
| bus_req | output | 1 | Address bus request for a castout |
| tstart | output | 1 | One-cycle start of the castout tenure |
| push_addr | output | ADDR_W | Line-aligned castout address |
| push_type | output | TYPE_W | Castout transaction type, write-with-kill code when `tstart` is high |
| push_done | output | 1 | Tells the cache that the line has been pushed |
| busy | output | 1 | Castout pending, new snoops are not answered |

## Verification
The assertions take two things for granted. First, a snoop strobe arrives only while the response logic is idle or a castout is pending, never during another snoop's window. Second, `artry_in` is meaningful only in the window cycle. The stimulus meets both conditions. Each scenario runs to completion and leaves idle cycles before the next strobe, and the only strobes that overlap earlier work are the deliberate ones issued during a pending push. Grant delays of several cycles exercise the held request, and a grant in the first request cycle checks the shortest path to `tstart`.

// File: rtl/spc_pkg.sv
// Package: shared encodings for the snoop response and push controller.
// Assumes: snoop lookup is a 2-bit code; transaction types are TYPE_W wide.
package spc_pkg;
    typedef enum logic [1:0] {
        SNP_MISS = 2'b00,
        SNP_SHR  = 2'b01,
        SNP_EXC  = 2'b10,
        SNP_MOD  = 2'b11
    } snp_state_e;

    typedef enum logic [1:0] {
        R_IDLE = 2'd0,
        R_WAIT = 2'd1,
        R_WIN  = 2'd2,
        R_EXT  = 2'd3
    } resp_state_e;

    typedef enum logic [1:0] {
        P_IDLE = 2'd0,
        P_REQ  = 2'd1,
        P_TS   = 2'd2
    } push_state_e;
endpackage

// File: rtl/spc_resp.sv
// Module: spc_resp
// Answers one snoop at a time. It counts to the retry window, drives HIT
// and shapes its length (one cycle means memory must snarf, two cycles mean
// it need not), and flags a castout when a modified hit is retried.
// Assumes: no new strobe arrives while a response is in flight.
module spc_resp
    import spc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int TYPE_W     = 4,
    parameter int RETRY_WIN  = 2,
    parameter logic [TYPE_W-1:0] RWITM_CODE = 4'h6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic [1:0]        snp_state,
    input  logic [TYPE_W-1:0] snp_type,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              artry_in,
    input  logic              push_busy,
    output logic              hit_o,
    output logic              launch_o,
    output logic [ADDR_W-1:0] line_addr_o
);
    localparam int CNT_W = (RETRY_WIN > 2) ? $clog2(RETRY_WIN) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RETRY_WIN - 2);

    resp_state_e       state;
    logic [CNT_W-1:0]  cnt;
    logic              cap_mod;
    logic              cap_rwitm;
    logic [ADDR_W-1:0] cap_addr;
    logic              long_hit;

    // Decode the castout trigger and the HIT length for the captured snoop.
    always_comb begin
        launch_o    = (state == R_WIN) && cap_mod && artry_in;
        long_hit    = !cap_mod || cap_rwitm;
        hit_o       = (state == R_WIN) || (state == R_EXT);
        line_addr_o = cap_addr;
    end

    // Advance the response through wait, window and extension cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= R_IDLE;
            cnt       <= '0;
            cap_mod   <= 1'b0;
            cap_rwitm <= 1'b0;
            cap_addr  <= '0;
        end else begin
            case (state)
                R_IDLE: if (snp_valid && !push_busy && snp_state != SNP_MISS) begin
                    state     <= R_WAIT;
                    cnt       <= CNT_LOAD;
                    cap_mod   <= (snp_state == SNP_MOD);
                    cap_rwitm <= (snp_type == RWITM_CODE);
                    cap_addr  <= snp_addr;
                end
                R_WAIT: begin
                    if (cnt == '0) state <= R_WIN;
                    else           cnt   <= cnt - 1'b1;
                end
                R_WIN: begin
                    if (launch_o)      state <= R_IDLE;
                    else if (long_hit) state <= R_EXT;
                    else               state <= R_IDLE;
                end
                default: state <= R_IDLE;
            endcase
        end
    end

    // HIT never lasts longer than two cycles (R3).
    p_hit_max2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && $past(hit_o)) |=> !hit_o);

    // A retried modified hit drops HIT in the next cycle (R7).
    p_push_drops_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |=> !hit_o);
endmodule

// File: rtl/spc_push.sv
// Module: spc_push
// Runs the castout: requests the address bus, waits for the grant, then
// issues a one-cycle write-with-kill tenure with the line-aligned address.
// Assumes: launch arrives only while this unit is idle.
module spc_push
    import spc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int TYPE_W   = 4,
    parameter int LINE_OFF = 5,
    parameter logic [TYPE_W-1:0] WWK_CODE = 4'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] line_addr,
    input  logic              bus_grant,
    output logic              bus_req,
    output logic              tstart,
    output logic              push_done,
    output logic [ADDR_W-1:0] push_addr,
    output logic [TYPE_W-1:0] push_type,
    output logic              busy
);
    push_state_e                 state;
    logic [ADDR_W-LINE_OFF-1:0]  line_q;

    // Drive the bus-side outputs from the push state.
    always_comb begin
        bus_req   = (state == P_REQ);
        tstart    = (state == P_TS);
        push_done = (state == P_TS);
        busy      = (state != P_IDLE);
        push_addr = {line_q, {LINE_OFF{1'b0}}};
        push_type = tstart ? WWK_CODE : '0;
    end

    // Sequence request, grant wait and tenure start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= P_IDLE;
            line_q <= '0;
        end else begin
            case (state)
                P_IDLE: if (launch) begin
                    state  <= P_REQ;
                    line_q <= line_addr[ADDR_W-1:LINE_OFF];
                end
                P_REQ:   if (bus_grant) state <= P_TS;
                default: state <= P_IDLE;
            endcase
        end
    end

    // Request is held until a grant is seen (R7).
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_grant) |=> bus_req);

    // Tenure start only follows a granted request (R8).
    p_ts_after_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tstart |-> $past(bus_req && bus_grant));

    // Tenure start is a single-cycle pulse (R8).
    p_ts_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tstart |=> !tstart);
endmodule

// File: rtl/snoop_push_ctrl.sv
// Module: snoop_push_ctrl (top)
// Connects the snoop response unit to the castout unit. The busy flag of
// the castout unit blocks new snoop responses while a push is pending.
// Assumes: RETRY_WIN >= 2 and LINE_OFF < ADDR_W.
module snoop_push_ctrl
    import spc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int TYPE_W    = 4,
    parameter int RETRY_WIN = 2,
    parameter int LINE_OFF  = 5,
    parameter logic [TYPE_W-1:0] RWITM_CODE = 4'h6,
    parameter logic [TYPE_W-1:0] WWK_CODE   = 4'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic [1:0]        snp_state,
    input  logic [TYPE_W-1:0] snp_type,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              artry_in,
    input  logic              bus_grant,
    output logic              hit_o,
    output logic              bus_req,
    output logic              tstart,
    output logic [ADDR_W-1:0] push_addr,
    output logic [TYPE_W-1:0] push_type,
    output logic              push_done,
    output logic              busy
);
    logic              launch;
    logic [ADDR_W-1:0] line_addr;

    spc_resp #(
        .ADDR_W(ADDR_W), .TYPE_W(TYPE_W),
        .RETRY_WIN(RETRY_WIN), .RWITM_CODE(RWITM_CODE)
    ) u_resp (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_state(snp_state),
        .snp_type(snp_type), .snp_addr(snp_addr),
        .artry_in(artry_in), .push_busy(busy),
        .hit_o(hit_o), .launch_o(launch), .line_addr_o(line_addr)
    );

    spc_push #(
        .ADDR_W(ADDR_W), .TYPE_W(TYPE_W),
        .LINE_OFF(LINE_OFF), .WWK_CODE(WWK_CODE)
    ) u_push (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .line_addr(line_addr), .bus_grant(bus_grant),
        .bus_req(bus_req), .tstart(tstart), .push_done(push_done),
        .push_addr(push_addr), .push_type(push_type), .busy(busy)
    );

    // A castout start means the cache is told about the push (R8).
    p_done_with_ts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tstart |-> (push_done && busy));

    // Request and intervention never overlap (R7).
    p_req_not_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !hit_o);
endmodule

// File: tb/sim_snoop_push_ctrl.sv
module sim_snoop_push_ctrl;
    localparam int ADDR_W = 32;
    localparam int TYPE_W = 4;
    localparam logic [TYPE_W-1:0] RWITM = 4'h6;
    localparam logic [TYPE_W-1:0] RD    = 4'h1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic snp_valid = 1'b0;
    logic [1:0] snp_state = 2'b00;
    logic [TYPE_W-1:0] snp_type = '0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic artry_in = 1'b0;
    logic bus_grant = 1'b0;
    logic hit_o, bus_req, tstart, push_done, busy;
    logic [ADDR_W-1:0] push_addr;
    logic [TYPE_W-1:0] push_type;

    always #2 clk = ~clk;

    snoop_push_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_state(snp_state),
        .snp_type(snp_type), .snp_addr(snp_addr), .artry_in(artry_in),
        .bus_grant(bus_grant), .hit_o(hit_o), .bus_req(bus_req), .tstart(tstart),
        .push_addr(push_addr), .push_type(push_type), .push_done(push_done),
        .busy(busy)
    );

    typedef struct {
        logic hit, br, ts, done, bsy;
        logic [ADDR_W-1:0] addr;
        string tag;
    } exp_t;

    exp_t q[$];
    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    // Monitor: compare one expected item per cycle, away from the edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if ({hit_o, bus_req, tstart, push_done, busy} !== {e.hit, e.br, e.ts, e.done, e.bsy}) begin
                n_fail++;
                $display("FAIL %s: hit/br/ts/done/busy actual %b%b%b%b%b expected %b%b%b%b%b",
                    e.tag, hit_o, bus_req, tstart, push_done, busy, e.hit, e.br, e.ts, e.done, e.bsy);
            end
            if (e.ts) begin
                n_run++;
                if (push_addr !== e.addr || push_type !== 4'h3) begin
                    n_fail++;
                    $display("FAIL %s: addr/type actual %h/%h expected %h/3", e.tag, push_addr, push_type, e.addr);
                end
            end
        end
    end

    // Driver step: push expectation for the current cycle, then advance.
    task automatic step(input string tag, input logic h, input logic br, input logic ts,
                        input logic bs, input logic [ADDR_W-1:0] a);
        exp_t e;
        e.hit = h; e.br = br; e.ts = ts; e.done = ts; e.bsy = bs; e.addr = a; e.tag = tag;
        q.push_back(e);
        @(posedge clk);
        #1;
    endtask

    // One snoop scenario: expectations come from the requirement timing.
    task automatic scen(input string tag, input logic [1:0] st, input logic [TYPE_W-1:0] ty,
                        input logic [ADDR_W-1:0] a, input logic rt, input int gd, input logic inj);
        logic is_hit, long_h, push;
        logic [ADDR_W-1:0] la;
        is_hit = (st != 2'b00);
        push   = (st == 2'b11) && rt;
        long_h = (st == 2'b01) || (st == 2'b10) || (st == 2'b11 && ty == RWITM);
        la     = a & ~32'h1f;
        snp_valid = 1'b1; snp_state = st; snp_type = ty; snp_addr = a;
        step(tag, 0, 0, 0, 0, '0);
        snp_valid = 1'b0; snp_state = 2'b00; snp_type = '0;
        step(tag, 0, 0, 0, 0, '0);
        artry_in = rt;
        step(tag, is_hit, 0, 0, 0, '0);
        artry_in = 1'b0;
        if (push) begin
            for (int k = 0; k <= gd; k++) begin
                bus_grant = (k == gd);
                snp_valid = inj && (k == 0);
                snp_state = (inj && k == 0) ? 2'b01 : 2'b00;
                step(tag, 0, 1, 0, 1, '0);
                snp_valid = 1'b0; snp_state = 2'b00;
            end
            bus_grant = 1'b0;
            step(tag, 0, 0, 1, 1, la);
        end else begin
            step(tag, is_hit && long_h, 0, 0, 0, '0);
        end
        for (int k = 0; k < 3; k++) step(tag, 0, 0, 0, 0, '0);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        step("R1", 0, 0, 0, 0, '0);
        rst_n = 1'b1;
        step("R1", 0, 0, 0, 0, '0);
        step("R1", 0, 0, 0, 0, '0);
        scen("R2",  2'b00, RD,    32'h0000_1234, 1'b0, 0, 1'b0);
        scen("R2",  2'b00, RD,    32'h0000_1234, 1'b1, 0, 1'b0);
        scen("R3",  2'b01, RD,    32'h1000_0040, 1'b0, 0, 1'b0);
        scen("R3",  2'b10, RD,    32'h1000_0080, 1'b0, 0, 1'b0);
        scen("R4",  2'b11, RD,    32'h2000_00c0, 1'b0, 0, 1'b0);
        scen("R5",  2'b11, RWITM, 32'h2000_0100, 1'b0, 0, 1'b0);
        scen("R6",  2'b01, RD,    32'h3000_0140, 1'b1, 0, 1'b0);
        scen("R6",  2'b10, RWITM, 32'h3000_0180, 1'b1, 0, 1'b0);
        scen("R7",  2'b11, RD,    32'h4000_01df, 1'b1, 0, 1'b0);
        scen("R8",  2'b11, RD,    32'hdead_beef, 1'b1, 4, 1'b0);
        scen("R7",  2'b11, RWITM, 32'h5555_5555, 1'b1, 2, 1'b0);
        scen("R9",  2'b11, RD,    32'hffff_ffff, 1'b1, 3, 1'b1);
        scen("R3",  2'b01, RD,    32'h0000_0020, 1'b0, 0, 1'b0);
        repeat (2) @(posedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule